// File: doc/BRIEF.md
# Operand Address Generator

This unit turns the 6-bit operand-addressing field of a 16/32-bit CISC instruction into an operand address. For immediate operands it returns the operand value instead. A single `start` pulse captures the field, the operand size, a control-only flag and the low 24 bits of the program counter. The unit then works through its steps on its own. It reads base and index registers through one read port into an external 16-entry register file: entries 0–7 are the data registers and 8–15 the address registers. It pulls 16-bit extension words from the instruction stream over a valid/ready handshake.

When the result is ready, `done` is high for exactly one cycle. In that cycle the unit presents the address, the extra cycle cost of the mode and two legality flags. For the auto-increment and auto-decrement modes it also presents an address-register write-back. The memory access, the instruction decoder and the register storage are outside the block.

Top module: `agu_ea_unit`

## Requirements
- R1: After synchronous active-high reset the unit is idle: `done`, `wb_en` and `ext_ready` are low.
- R2: Field codes 0x00–0x0F (register 0–15 direct) return that register's contents on `ea_out`. They take no extension word, `wb_en` stays low and `extra_cycles` is 0.
- R3: Codes 0x10–0x17 (indirect) return register 8+n. Codes 0x18–0x1F (post-increment) return the old value and write back old+step. Codes 0x20–0x27 (pre-decrement) return old−step and write the same value back. `wb_idx` is n. The step is 1, 2 or 4 for size code 0 (byte), 1 (word) or 2 (long), except that it is 2 for byte size when n is 7.
- R4: Code 0x28–0x2F returns register 8+n plus the sign-extended extension word. Code 0x38 returns the sign-extended word. Code 0x39 takes two words and returns {first, second}.
- R5: Codes 0x30–0x37 and 0x3B take one extension word. Its bits 15:12 name the index register (0–15). Bit 11 set selects the full 32-bit index; clear selects the sign-extended low 16 bits. Bits 7:0 are a signed displacement. The result is base + index + displacement.
- R6: For codes 0x3A and 0x3B the base is the 24-bit `pc_lo` sign-extended to 32 bits. `pc_lo` is the address of the extension word. Code 0x3A adds the sign-extended extension word.
- R7: Code 0x3C returns an immediate. For byte size it takes one word and returns its low byte zero-extended. For word size it takes one word and returns it zero-extended. For long size it takes two words and returns {first, second}.
- R8: `extra_cycles` is, for byte or word versus long: indirect and post-increment 4/8, pre-decrement 6/10, register-relative 8/12, register-indexed 10/14, absolute short 8/12, absolute long 12/16, PC-relative 8/12, PC-indexed 10/14, immediate 4/8.
- R9: `can_write` is low for codes above 0x39. Codes above 0x3C drive both flags low, take no extension word and report 0 extra cycles.
- R10: With `ctrl_req` high, codes 0x00–0x0F, 0x18–0x27 and 0x3C drive both flags low. Every other code keeps the result it has with `ctrl_req` low.
- R11: `done` lasts exactly one cycle. `ext_ready` is high only while the unit waits for an extension word and is never high together with `done`. While `ext_valid` is low the unit waits without consuming. Each request consumes exactly the number of words its mode needs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a request; sampled only while idle |
| ea_field | input | 6 | Operand-addressing field |
| op_size | input | 2 | 0 byte, 1 word, 2 long |
| ctrl_req | input | 1 | Address-only (control) request |
| pc_lo | input | 24 | Low 24 bits of the address of the first extension word |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data, same cycle |
| ext_word | input | 16 | Extension word from the instruction stream |
| ext_valid | input | 1 | Extension word present |
| ext_ready | output | 1 | Unit takes the word this cycle if valid |
| done | output | 1 | One-cycle result strobe |
| ea_out | output | 32 | Address or immediate value, valid with `done` |
| wb_en | output | 1 | Address-register write-back enable |
| wb_idx | output | 3 | Address register to update |
| wb_data | output | 32 | Write-back value |
| extra_cycles | output | 5 | Mode cycle cost |
| can_read | output | 1 | Mode legal for a read |
| can_write | output | 1 | Mode legal for a write |

## Verification
The checker relies on two things. `start` is only sampled while the unit is idle, and the register-file read data answers `rf_rd_idx` in the same cycle. From these it keeps its own copy of the pending field and size, and it checks the write-back and legality rules against that copy. The bench drives `start` only between requests and models the register file as a combinational array. It supplies exactly the number of words the mode needs, sometimes with idle gaps, so the handshake is exercised under stalls without overrunning a request.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int DW    = 32;
  localparam int PCW   = 24;
  localparam int CYC_W = 5;

  typedef enum logic [3:0] {
    M_DREG, M_AREG, M_IND, M_POST, M_PRE, M_D16, M_IDX,
    M_ABSW, M_ABSL, M_PCD, M_PCX, M_IMM, M_BAD
  } mode_t;

  function automatic mode_t f_mode(input logic [5:0] ea);
    case (ea[5:3])
      3'd0: f_mode = M_DREG;
      3'd1: f_mode = M_AREG;
      3'd2: f_mode = M_IND;
      3'd3: f_mode = M_POST;
      3'd4: f_mode = M_PRE;
      3'd5: f_mode = M_D16;
      3'd6: f_mode = M_IDX;
      default:
        case (ea[2:0])
          3'd0: f_mode = M_ABSW;
          3'd1: f_mode = M_ABSL;
          3'd2: f_mode = M_PCD;
          3'd3: f_mode = M_PCX;
          3'd4: f_mode = M_IMM;
          default: f_mode = M_BAD;
        endcase
    endcase
  endfunction

  // cost for byte/word; long adds four to every memory mode
  function automatic logic [CYC_W-1:0] f_cycles(input mode_t m, input logic is_long);
    logic [CYC_W-1:0] c;
    case (m)
      M_IND, M_POST, M_IMM:  c = 5'd4;
      M_PRE:                 c = 5'd6;
      M_D16, M_ABSW, M_PCD:  c = 5'd8;
      M_IDX, M_PCX:          c = 5'd10;
      M_ABSL:                c = 5'd12;
      default:               c = 5'd0;
    endcase
    f_cycles = (is_long && c != 0) ? c + 5'd4 : c;
  endfunction

  function automatic logic [1:0] f_ext_words(input mode_t m, input logic is_long);
    case (m)
      M_D16, M_IDX, M_ABSW, M_PCD, M_PCX: f_ext_words = 2'd1;
      M_ABSL:                             f_ext_words = 2'd2;
      M_IMM:                              f_ext_words = is_long ? 2'd2 : 2'd1;
      default:                            f_ext_words = 2'd0;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_step(input logic [1:0] sz, input logic is_sp);
    case (sz)
      2'd0:    f_step = is_sp ? 32'd2 : 32'd1;
      2'd1:    f_step = 32'd2;
      default: f_step = 32'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] f_sx16(input logic [15:0] v);
    f_sx16 = {{(DW-16){v[15]}}, v};
  endfunction

  function automatic logic [DW-1:0] f_sx8(input logic [7:0] v);
    f_sx8 = {{(DW-8){v[7]}}, v};
  endfunction

  function automatic logic [DW-1:0] f_sx_pc(input logic [PCW-1:0] v);
    f_sx_pc = {{(DW-PCW){v[PCW-1]}}, v};
  endfunction
endpackage

// File: rtl/agu_ea_decode.sv
module agu_ea_decode
  import agu_pkg::*;
(
  input  logic [5:0]       ea,
  input  logic [1:0]       sz,
  input  logic             ctrl,
  output mode_t            mode,
  output logic [1:0]       n_ext,
  output logic [CYC_W-1:0] cycles,
  output logic             can_rd,
  output logic             can_wr,
  output logic [3:0]       base_idx
);
  logic is_long;
  logic ctrl_bad;
  logic exists;

  assign is_long  = sz[1];
  assign mode     = f_mode(ea);
  assign n_ext    = f_ext_words(mode, is_long);
  assign cycles   = f_cycles(mode, is_long);
  assign base_idx = (mode == M_DREG) ? {1'b0, ea[2:0]} : {1'b1, ea[2:0]};
  assign exists   = (mode != M_BAD);
  assign ctrl_bad = ctrl && (mode inside {M_DREG, M_AREG, M_POST, M_PRE, M_IMM});
  assign can_rd   = exists && !ctrl_bad;
  assign can_wr   = exists && !ctrl_bad && !(mode inside {M_PCD, M_PCX, M_IMM});
endmodule

// File: rtl/agu_ea_calc.sv
module agu_ea_calc
  import agu_pkg::*;
(
  input  mode_t           mode,
  input  logic [1:0]      sz,
  input  logic            is_sp,
  input  logic [DW-1:0]   base,
  input  logic [PCW-1:0]  pc,
  input  logic [15:0]     w1,
  input  logic [15:0]     w2,
  input  logic [DW-1:0]   idx_raw,
  output logic [DW-1:0]   addr,
  output logic [DW-1:0]   wb_val
);
  logic [DW-1:0] step;
  logic [DW-1:0] index;
  logic [DW-1:0] pc_base;

  assign step    = f_step(sz, is_sp);
  assign index   = w1[11] ? idx_raw : f_sx16(idx_raw[15:0]);
  assign pc_base = f_sx_pc(pc);
  assign wb_val  = (mode == M_POST) ? base + step : base - step;

  always_comb begin
    case (mode)
      M_DREG, M_AREG, M_IND, M_POST: addr = base;
      M_PRE:  addr = base - step;
      M_D16:  addr = base + f_sx16(w1);
      M_IDX:  addr = base + index + f_sx8(w1[7:0]);
      M_ABSW: addr = f_sx16(w1);
      M_ABSL: addr = {w1, w2};
      M_PCD:  addr = pc_base + f_sx16(w1);
      M_PCX:  addr = pc_base + index + f_sx8(w1[7:0]);
      M_IMM:  addr = sz[1] ? {w1, w2} : (sz == 2'd0) ? {24'd0, w1[7:0]} : {16'd0, w1};
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/agu_ea_unit.sv
module agu_ea_unit
  import agu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [5:0]       ea_field,
  input  logic [1:0]       op_size,
  input  logic             ctrl_req,
  input  logic [PCW-1:0]   pc_lo,
  output logic [3:0]       rf_rd_idx,
  input  logic [DW-1:0]    rf_rd_data,
  input  logic [15:0]      ext_word,
  input  logic             ext_valid,
  output logic             ext_ready,
  output logic             done,
  output logic [DW-1:0]    ea_out,
  output logic             wb_en,
  output logic [2:0]       wb_idx,
  output logic [DW-1:0]    wb_data,
  output logic [CYC_W-1:0] extra_cycles,
  output logic             can_read,
  output logic             can_write
);
  typedef enum logic [2:0] {ST_IDLE, ST_BASE, ST_EXT1, ST_EXT2, ST_INDEX, ST_DONE} state_t;

  state_t         state_q;
  logic [5:0]     ea_q;
  logic [1:0]     sz_q;
  logic           ctl_q;
  logic [PCW-1:0] pc_q;
  logic [DW-1:0]  base_q, idx_q;
  logic [15:0]    w1_q, w2_q;

  mode_t            mode;
  logic [1:0]       n_ext;
  logic [CYC_W-1:0] cyc;
  logic             rd_ok, wr_ok;
  logic [3:0]       base_idx;
  logic [DW-1:0]    addr, wb_val;
  logic             take_word;
  logic             is_indexed;

  agu_ea_decode u_dec (
    .ea(ea_q), .sz(sz_q), .ctrl(ctl_q), .mode(mode), .n_ext(n_ext),
    .cycles(cyc), .can_rd(rd_ok), .can_wr(wr_ok), .base_idx(base_idx)
  );

  agu_ea_calc u_calc (
    .mode(mode), .sz(sz_q), .is_sp(ea_q[2:0] == 3'd7), .base(base_q), .pc(pc_q),
    .w1(w1_q), .w2(w2_q), .idx_raw(idx_q), .addr(addr), .wb_val(wb_val)
  );

  assign is_indexed = (mode == M_IDX) || (mode == M_PCX);
  assign ext_ready  = (state_q == ST_EXT1) || (state_q == ST_EXT2);
  assign take_word  = ext_ready && ext_valid;
  assign rf_rd_idx  = (state_q == ST_INDEX) ? w1_q[15:12] : base_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ea_q    <= '0;
      sz_q    <= '0;
      ctl_q   <= 1'b0;
      pc_q    <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      w1_q    <= '0;
      w2_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          ea_q    <= ea_field;
          sz_q    <= op_size;
          ctl_q   <= ctrl_req;
          pc_q    <= pc_lo;
          state_q <= ST_BASE;
        end
        ST_BASE: begin
          base_q  <= rf_rd_data;
          state_q <= (n_ext != 2'd0) ? ST_EXT1 : ST_DONE;
        end
        ST_EXT1: if (take_word) begin
          w1_q <= ext_word;
          if (n_ext == 2'd2)   state_q <= ST_EXT2;
          else if (is_indexed) state_q <= ST_INDEX;
          else                 state_q <= ST_DONE;
        end
        ST_EXT2: if (take_word) begin
          w2_q    <= ext_word;
          state_q <= ST_DONE;
        end
        ST_INDEX: begin
          idx_q   <= rf_rd_data;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done         = (state_q == ST_DONE);
  assign ea_out       = done ? addr : '0;
  assign wb_en        = done && (mode == M_POST || mode == M_PRE);
  assign wb_idx       = ea_q[2:0];
  assign wb_data      = wb_val;
  assign extra_cycles = done ? cyc : '0;
  assign can_read     = done && rd_ok;
  assign can_write    = done && wr_ok;
endmodule

// File: rtl/agu_ea_unit_chk.sv
module agu_ea_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [5:0]  ea_field,
  input logic [1:0]  op_size,
  input logic        done,
  input logic        ext_ready,
  input logic [31:0] ea_out,
  input logic        wb_en,
  input logic [2:0]  wb_idx,
  input logic [31:0] wb_data,
  input logic [4:0]  extra_cycles,
  input logic        can_write,
  input logic        can_read
);
  logic        busy;
  logic [5:0]  pend_ea;
  logic [1:0]  pend_sz;
  logic [31:0] pend_step;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pend_ea <= '0;
      pend_sz <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      pend_ea <= ea_field;
      pend_sz <= op_size;
    end else if (done) begin
      busy <= 1'b0;
    end
  end

  assign pend_step = (pend_sz == 2'd2) ? 32'd4 :
                     (pend_sz == 2'd1 || pend_ea[2:0] == 3'd7) ? 32'd2 : 32'd1;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R11
  AST_READY_NOT_DONE: assert property (@(posedge clk) disable iff (rst) ext_ready |-> !done); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> (!done && !ext_ready)); // R11
  AST_WB_MODES: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (done && pend_ea >= 6'h18 && pend_ea <= 6'h27 && wb_idx == pend_ea[2:0])); // R3
  AST_POST_STEP: assert property (@(posedge clk) disable iff (rst)
    (done && pend_ea[5:3] == 3'd3) |-> (wb_en && wb_data == ea_out + pend_step)); // R3
  AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
    (done && pend_ea[5:3] == 3'd4) |-> (wb_en && wb_data == ea_out)); // R3
  AST_REG_FREE: assert property (@(posedge clk) disable iff (rst)
    (done && pend_ea < 6'h10) |-> (extra_cycles == 5'd0 && !wb_en)); // R2
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (done && pend_ea > 6'h3C) |-> (!can_read && !can_write && extra_cycles == 5'd0)); // R9
  AST_PC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (done && pend_ea >= 6'h3A) |-> !can_write); // R9
endmodule

bind agu_ea_unit agu_ea_unit_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .ea_field(ea_field), .op_size(op_size),
  .done(done), .ext_ready(ext_ready), .ea_out(ea_out), .wb_en(wb_en),
  .wb_idx(wb_idx), .wb_data(wb_data), .extra_cycles(extra_cycles),
  .can_write(can_write), .can_read(can_read)
);

// File: tb/agu_ea_unit_tb_top.sv
module agu_ea_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  ea_field = '0;
  logic [1:0]  op_size = '0;
  logic        ctrl_req = 1'b0;
  logic [23:0] pc_lo = '0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic [15:0] ext_word = '0;
  logic        ext_valid = 1'b0;
  logic        ext_ready, done, wb_en, can_read, can_write;
  logic [31:0] ea_out, wb_data;
  logic [2:0]  wb_idx;
  logic [4:0]  extra_cycles;

  logic [31:0] regs [16];
  int checks = 0;
  int errors = 0;

  logic [31:0] r_addr, r_wbd;
  logic        r_wbe, r_rd, r_wr;
  logic [2:0]  r_wbi;
  logic [4:0]  r_cyc;
  int          r_used;

  always #5 clk = ~clk;
  assign rf_rd_data = regs[rf_rd_idx];

  agu_ea_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .ea_field(ea_field), .op_size(op_size),
    .ctrl_req(ctrl_req), .pc_lo(pc_lo), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .ext_word(ext_word), .ext_valid(ext_valid), .ext_ready(ext_ready), .done(done),
    .ea_out(ea_out), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .extra_cycles(extra_cycles), .can_read(can_read), .can_write(can_write)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request: start pulse, word feeder (optional gaps), capture at done
  task automatic run(input logic [5:0] ea, input logic [1:0] sz, input logic ctl,
                     input logic [23:0] pc, input int nw, input logic [15:0] w0,
                     input logic [15:0] w1, input bit stall);
    bit got = 0;
    bit gap = 0;
    int ptr = 0;
    @(negedge clk);
    start = 1'b1; ea_field = ea; op_size = sz; ctrl_req = ctl; pc_lo = pc;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 64; c++) begin
      ext_valid = (ptr < nw) && !(stall && gap);
      ext_word  = (ptr == 0) ? w0 : w1;
      gap = !gap;
      #1;
      if (done) begin
        r_addr = ea_out; r_wbe = wb_en; r_wbi = wb_idx; r_wbd = wb_data;
        r_cyc = extra_cycles; r_rd = can_read; r_wr = can_write;
        got = 1;
        break;
      end
      if (ext_valid && ext_ready) ptr++;
      @(negedge clk);
    end
    ext_valid = 1'b0;
    r_used = ptr;
    chk("R11 request completes", {31'd0, got}, 32'd1);
    @(negedge clk);
    chk("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 done after reset", {31'd0, done}, 32'd0);
    chk("R1 wb_en after reset", {31'd0, wb_en}, 32'd0);
    chk("R1 ext_ready after reset", {31'd0, ext_ready}, 32'd0);
  endtask

  task automatic t_reg_direct;
    run(6'h03, 2'd2, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R2 D3 value", r_addr, regs[3]);
    chk("R2 cycles", {27'd0, r_cyc}, 32'd0);
    chk("R2 no wb", {31'd0, r_wbe}, 32'd0);
    run(6'h0C, 2'd1, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R2 A4 value", r_addr, regs[12]);
    chk("R2 no words", r_used, 32'd0);
  endtask

  task automatic t_incdec;
    run(6'h12, 2'd2, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 indirect addr", r_addr, regs[10]);
    chk("R8 indirect long", {27'd0, r_cyc}, 32'd8);
    chk("R3 indirect no wb", {31'd0, r_wbe}, 32'd0);
    run(6'h1A, 2'd0, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 post addr", r_addr, regs[10]);
    chk("R3 post wb byte", r_wbd, regs[10] + 1);
    chk("R3 post wb_en", {31'd0, r_wbe}, 32'd1);
    chk("R3 post wb_idx", {29'd0, r_wbi}, 32'd2);
    chk("R8 post byte", {27'd0, r_cyc}, 32'd4);
    run(6'h1F, 2'd0, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 A7 byte post step 2", r_wbd, regs[15] + 2);
    run(6'h25, 2'd2, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 pre long addr", r_addr, regs[13] - 4);
    chk("R3 pre long wb", r_wbd, regs[13] - 4);
    chk("R8 pre long", {27'd0, r_cyc}, 32'd10);
    run(6'h27, 2'd0, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 A7 byte pre step 2", r_addr, regs[15] - 2);
    chk("R8 pre byte", {27'd0, r_cyc}, 32'd6);
    run(6'h21, 2'd1, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R3 pre word", r_addr, regs[9] - 2);
  endtask

  task automatic t_disp_abs;
    run(6'h2B, 2'd1, 1'b0, 24'd0, 1, 16'hFFF0, 16'd0, 0);
    chk("R4 d16 negative", r_addr, regs[11] - 16);
    chk("R8 d16 word", {27'd0, r_cyc}, 32'd8);
    run(6'h38, 2'd2, 1'b0, 24'd0, 1, 16'h8000, 16'd0, 1);
    chk("R4 abs short sext", r_addr, 32'hFFFF_8000);
    chk("R8 abs short long", {27'd0, r_cyc}, 32'd12);
    run(6'h39, 2'd1, 1'b0, 24'd0, 2, 16'h0012, 16'h3456, 1);
    chk("R4 abs long order", r_addr, 32'h0012_3456);
    chk("R11 two words under stall", r_used, 32'd2);
    chk("R8 abs long word", {27'd0, r_cyc}, 32'd12);
  endtask

  task automatic t_index;
    run(6'h34, 2'd1, 1'b0, 24'd0, 1, 16'h28FC, 16'd0, 0);
    chk("R5 long index neg disp", r_addr, regs[12] + regs[2] - 4);
    chk("R8 indexed word", {27'd0, r_cyc}, 32'd10);
    run(6'h34, 2'd2, 1'b0, 24'd0, 1, 16'hE010, 16'd0, 1);
    chk("R5 word index sext", r_addr, regs[12] + 32'hFFFF_9000 + 16);
    chk("R8 indexed long", {27'd0, r_cyc}, 32'd14);
  endtask

  task automatic t_pc;
    run(6'h3A, 2'd1, 1'b0, 24'h80_0010, 1, 16'h0004, 16'd0, 0);
    chk("R6 pc disp sext24", r_addr, 32'hFF80_0014);
    chk("R8 pc disp", {27'd0, r_cyc}, 32'd8);
    chk("R9 pc not writable", {31'd0, r_wr}, 32'd0);
    run(6'h3B, 2'd2, 1'b0, 24'h12_3400, 1, 16'h1802, 16'd0, 0);
    chk("R6 pc indexed", r_addr, 32'h0012_3400 + regs[1] + 2);
    chk("R8 pc indexed long", {27'd0, r_cyc}, 32'd14);
  endtask

  task automatic t_imm;
    run(6'h3C, 2'd0, 1'b0, 24'd0, 1, 16'h12AB, 16'd0, 0);
    chk("R7 imm byte", r_addr, 32'h0000_00AB);
    chk("R8 imm byte", {27'd0, r_cyc}, 32'd4);
    run(6'h3C, 2'd1, 1'b0, 24'd0, 1, 16'hBEEF, 16'd0, 0);
    chk("R7 imm word", r_addr, 32'h0000_BEEF);
    run(6'h3C, 2'd2, 1'b0, 24'd0, 2, 16'hDEAD, 16'hBEEF, 1);
    chk("R7 imm long", r_addr, 32'hDEAD_BEEF);
    chk("R8 imm long", {27'd0, r_cyc}, 32'd8);
    chk("R9 imm not writable", {31'd0, r_wr}, 32'd0);
  endtask

  task automatic t_legal;
    run(6'h3D, 2'd1, 1'b0, 24'd0, 2, 16'h1111, 16'h2222, 0);
    chk("R9 bad code read", {31'd0, r_rd}, 32'd0);
    chk("R9 bad code write", {31'd0, r_wr}, 32'd0);
    chk("R9 bad code no words", r_used, 32'd0);
    chk("R9 bad code cycles", {27'd0, r_cyc}, 32'd0);
    run(6'h00, 2'd1, 1'b0, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R9 data reg writable", {30'd0, r_rd, r_wr}, 32'd3);
    run(6'h10, 2'd1, 1'b1, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R10 ctrl indirect ok", {30'd0, r_rd, r_wr}, 32'd3);
    run(6'h18, 2'd1, 1'b1, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R10 ctrl post illegal", {30'd0, r_rd, r_wr}, 32'd0);
    run(6'h05, 2'd1, 1'b1, 24'd0, 0, 16'd0, 16'd0, 0);
    chk("R10 ctrl reg illegal", {30'd0, r_rd, r_wr}, 32'd0);
    run(6'h3C, 2'd1, 1'b1, 24'd0, 1, 16'd7, 16'd0, 0);
    chk("R10 ctrl imm illegal", {30'd0, r_rd, r_wr}, 32'd0);
    run(6'h3A, 2'd1, 1'b1, 24'd0, 1, 16'd7, 16'd0, 0);
    chk("R10 ctrl pc read only", {30'd0, r_rd, r_wr}, 32'd2);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0001_0000 * i + 32'h100;
    regs[14] = 32'h1234_9000;
    regs[15] = 32'h0000_8000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_reg_direct();
    t_incdec();
    t_disp_abs();
    t_index();
    t_pc();
    t_imm();
    t_legal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200us;
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule